// File: doc/BRIEF.md
# Mixed-Granularity Dual-Port RAM

This block is a synchronous two-port RAM in which each port has its own write-enable lane width. One port may write whole words while the other writes 8-bit or 16-bit lanes. Both ports reach the same contents. Each port can be set to a combinational read or to a registered read, and a registered port has its own choice of read-during-write behaviour.

Internally, the storage is cut into equal slices. The width of a slice is the greatest common divisor of the two ports' effective lane widths. Every slice holds the full depth and is addressed by each port's own address. Each slice takes its write strobe from whichever enable bit of a port covers its bit range, so each port keeps its enables at its own width. When the common divisor equals the word width, a single slice holds the whole word. Power-up contents come from a flattened parameter vector.

There is no state machine. The only sequential elements are the storage slices and the per-slice registered read outputs.

Top module: `mixed_grain_ram`

## Requirements
- R1: A lane width of 0 means the whole word. Such a port has a single enable bit, and setting it writes all WIDTH bits.
- R2: Storage slice i holds word bits [i*G +: G], where G is the greatest common divisor of the two effective lane widths. A read returns the slices side by side, so any data written by one port reads back unchanged through the other port.
- R3: A port writes word bits [k*gp +: gp] only when bit k of its enable vector is 1, where gp is that port's lane width. Bits under a cleared enable keep their old value, and an all-zero enable changes nothing.
- R4: At power-up, word a holds INIT_FLAT[a*WIDTH +: WIDTH].
- R5: A registered port's read data changes only after a clock edge at which its read enable is 1. Otherwise the read data holds its value.
- R6: A combinational port's read data always shows the current contents at its address. This includes a write that landed at the previous edge and a change of address with no clock edge.
- R7: On a registered port in old-data mode (RDW_OLD = 0), a read returns the contents from before that edge's writes.
- R8: On a registered port in new-data mode (RDW_NEW = 1), a read returns the port's own write data in the lanes it writes in that cycle, and the old contents in the other lanes.
- R9: On a registered port in hold mode (RDW_HOLD = 2), the lanes the port writes in that cycle keep their previous read value, and the other lanes load the stored data.
- R10: When both ports write the same lane of the same address in one cycle, port B's data is stored.
- R11: While rst_n is low at a clock edge, every registered read output becomes zero. Reset does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read registers |
| a_addr | input | $clog2(DEPTH) | Port A word address |
| a_we | input | WIDTH/gA | Port A lane write enables (gA = GRAN_A, or WIDTH if GRAN_A is 0) |
| a_re | input | 1 | Port A read enable (registered reads only) |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A read data |
| b_addr | input | $clog2(DEPTH) | Port B word address |
| b_we | input | WIDTH/gB | Port B lane write enables (gB = GRAN_B, or WIDTH if GRAN_B is 0) |
| b_re | input | 1 | Port B read enable (registered reads only) |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B read data |

## Verification
Two configurations are used. The main one pairs an 8-bit old-data port with a 16-bit new-data port. It first runs an address sweep against computed initial words, which tells a wrong slice offset or init mapping apart from a write fault. Random traffic follows, with independent enable patterns on each port and frequent shared addresses. This mix separates lane-index errors on each port, read-during-write mistakes within a port, and the wrong winner on a same-lane collision. A second configuration pairs a whole-word hold-mode port with a combinational byte port. Directed writes there show whether the single enable covers the full word, whether combinational reads track writes and address changes without an edge, and whether hold mode freezes only the written lanes.

// File: rtl/mgr_pkg.sv
package mgr_pkg;

    typedef enum logic [1:0] {
        RDW_OLD  = 2'd0,
        RDW_NEW  = 2'd1,
        RDW_HOLD = 2'd2
    } rdw_mode_e;

    function automatic int unsigned eff_gran(int unsigned gran, int unsigned width);
        return (gran == 0) ? width : gran;
    endfunction

    function automatic int unsigned gcd2(int unsigned x, int unsigned y);
        int unsigned p;
        int unsigned q;
        int unsigned t;
        p = x;
        q = y;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

endpackage

// File: rtl/lane_strobe_map.sv
module lane_strobe_map #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned GRAN_EFF = 8,
    parameter int unsigned BANK_W   = 8
) (
    input  logic [WIDTH/GRAN_EFF-1:0] we_vec,
    output logic [WIDTH/BANK_W-1:0]   strobe
);
    localparam int unsigned NBANK   = WIDTH / BANK_W;
    localparam int unsigned PER_EN  = GRAN_EFF / BANK_W;

    for (genvar i = 0; i < NBANK; i++) begin : g_lane
        localparam int unsigned SEL = (i * BANK_W) / GRAN_EFF;
        assign strobe[i] = we_vec[SEL];
    end

    // Each enable bit must fan out to exactly PER_EN slices.
    always_comb begin
        if (!$isunknown(we_vec)) begin
            assert_strobe_count_R3: assert ($countones(strobe) == $countones(we_vec) * PER_EN)
                else $error("slice strobe count disagrees with enable vector");
        end
    end

endmodule

// File: rtl/bank_read_stage.sv
module bank_read_stage
    import mgr_pkg::*;
#(
    parameter int unsigned BW    = 8,
    parameter rdw_mode_e   MODE  = RDW_OLD,
    parameter bit          ASYNC = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] cur_data,
    output logic [BW-1:0] rdata
);

    if (ASYNC) begin : g_async
        logic unused_inputs;
        assign unused_inputs = ^{clk, rst_n, re, wr, wdata};
        assign rdata = cur_data;
    end else begin : g_reg
        logic [BW-1:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (re) begin
                if (MODE == RDW_OLD) begin
                    q <= cur_data;
                end else if (MODE == RDW_NEW) begin
                    q <= wr ? wdata : cur_data;
                end else begin
                    if (!wr) q <= cur_data;
                end
            end
        end

        assign rdata = q;

        assert_reset_clear_R11: assert property (@(posedge clk)
            !rst_n |=> (q == '0))
            else $error("read register not cleared by reset");

        assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !re |=> $stable(q))
            else $error("read data moved without read enable");

        if (MODE == RDW_OLD) begin : g_chk_old
            assert_old_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
                re |=> (q == $past(cur_data)))
                else $error("old-data read returned wrong value");
        end else if (MODE == RDW_NEW) begin : g_chk_new
            assert_new_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (re && wr) |=> (q == $past(wdata)))
                else $error("new-data read did not forward write data");
        end else begin : g_chk_hold
            assert_hold_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (re && wr) |=> $stable(q))
                else $error("hold-mode read changed during write");
        end
    end

endmodule

// File: rtl/grain_bank.sv
module grain_bank
    import mgr_pkg::*;
#(
    parameter int unsigned            WIDTH     = 32,
    parameter int unsigned            DEPTH     = 256,
    parameter int unsigned            BW        = 8,
    parameter int unsigned            LO        = 0,
    parameter int unsigned            AW        = 8,
    parameter logic [DEPTH*WIDTH-1:0] INIT_FLAT = '0,
    parameter rdw_mode_e              MODE_A    = RDW_OLD,
    parameter rdw_mode_e              MODE_B    = RDW_OLD,
    parameter bit                     ASYNC_A   = 1'b0,
    parameter bit                     ASYNC_B   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_wr,
    input  logic          a_re,
    input  logic [BW-1:0] a_wdata,
    output logic [BW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_wr,
    input  logic          b_re,
    input  logic [BW-1:0] b_wdata,
    output logic [BW-1:0] b_rdata
);

    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] a_cur;
    logic [BW-1:0] b_cur;

    initial begin
        for (int w = 0; w < DEPTH; w++) begin
            mem[w] = INIT_FLAT[w*WIDTH + LO +: BW];
        end
    end

    // Port B is applied last so it wins a same-slice, same-address clash.
    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
    end

    assign a_cur = mem[a_addr];
    assign b_cur = mem[b_addr];

    bank_read_stage #(.BW(BW), .MODE(MODE_A), .ASYNC(ASYNC_A)) u_rd_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .re       (a_re),
        .wr       (a_wr),
        .wdata    (a_wdata),
        .cur_data (a_cur),
        .rdata    (a_rdata)
    );

    bank_read_stage #(.BW(BW), .MODE(MODE_B), .ASYNC(ASYNC_B)) u_rd_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .re       (b_re),
        .wr       (b_wr),
        .wdata    (b_wdata),
        .cur_data (b_cur),
        .rdata    (b_rdata)
    );

    assert_b_wins_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && (a_addr == b_addr)) |=> (mem[$past(b_addr)] == $past(b_wdata)))
        else $error("same-slice clash not resolved in favour of port B");

    assert_unwritten_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_wr && !b_wr) |=> (mem[$past(a_addr)] == $past(a_cur)))
        else $error("slice content changed without a strobe");

endmodule

// File: rtl/mixed_grain_ram.sv
module mixed_grain_ram
    import mgr_pkg::*;
#(
    parameter int unsigned            WIDTH     = 32,
    parameter int unsigned            DEPTH     = 256,
    parameter int unsigned            GRAN_A    = 8,
    parameter int unsigned            GRAN_B    = 16,
    parameter rdw_mode_e              MODE_A    = RDW_OLD,
    parameter rdw_mode_e              MODE_B    = RDW_OLD,
    parameter bit                     ASYNC_A   = 1'b0,
    parameter bit                     ASYNC_B   = 1'b0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_FLAT = '0
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [$clog2(DEPTH)-1:0]                     a_addr,
    input  logic [WIDTH/mgr_pkg::eff_gran(GRAN_A,WIDTH)-1:0] a_we,
    input  logic                                         a_re,
    input  logic [WIDTH-1:0]                             a_wdata,
    output logic [WIDTH-1:0]                             a_rdata,
    input  logic [$clog2(DEPTH)-1:0]                     b_addr,
    input  logic [WIDTH/mgr_pkg::eff_gran(GRAN_B,WIDTH)-1:0] b_we,
    input  logic                                         b_re,
    input  logic [WIDTH-1:0]                             b_wdata,
    output logic [WIDTH-1:0]                             b_rdata
);

    localparam int unsigned GA_EFF = eff_gran(GRAN_A, WIDTH);
    localparam int unsigned GB_EFF = eff_gran(GRAN_B, WIDTH);
    localparam int unsigned BANK_W = gcd2(GA_EFF, GB_EFF);
    localparam int unsigned NBANK  = WIDTH / BANK_W;
    localparam int unsigned AW     = $clog2(DEPTH);

    logic [NBANK-1:0] a_strobe;
    logic [NBANK-1:0] b_strobe;

    lane_strobe_map #(.WIDTH(WIDTH), .GRAN_EFF(GA_EFF), .BANK_W(BANK_W)) u_map_a (
        .we_vec (a_we),
        .strobe (a_strobe)
    );

    lane_strobe_map #(.WIDTH(WIDTH), .GRAN_EFF(GB_EFF), .BANK_W(BANK_W)) u_map_b (
        .we_vec (b_we),
        .strobe (b_strobe)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        grain_bank #(
            .WIDTH     (WIDTH),
            .DEPTH     (DEPTH),
            .BW        (BANK_W),
            .LO        (i * BANK_W),
            .AW        (AW),
            .INIT_FLAT (INIT_FLAT),
            .MODE_A    (MODE_A),
            .MODE_B    (MODE_B),
            .ASYNC_A   (ASYNC_A),
            .ASYNC_B   (ASYNC_B)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_addr  (a_addr),
            .a_wr    (a_strobe[i]),
            .a_re    (a_re),
            .a_wdata (a_wdata[i*BANK_W +: BANK_W]),
            .a_rdata (a_rdata[i*BANK_W +: BANK_W]),
            .b_addr  (b_addr),
            .b_wr    (b_strobe[i]),
            .b_re    (b_re),
            .b_wdata (b_wdata[i*BANK_W +: BANK_W]),
            .b_rdata (b_rdata[i*BANK_W +: BANK_W])
        );
    end

endmodule

// File: tb/mixed_grain_ram_bench.sv
`timescale 1ns/1ps
module mixed_grain_ram_bench;
    import mgr_pkg::*;

    localparam int DEP = 16;

    function automatic logic [31:0] init_word(int a);
        return (32'(a) * 32'h0103_0507) ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [DEP*32-1:0] build_init();
        logic [DEP*32-1:0] f;
        for (int a = 0; a < DEP; a++) f[a*32 +: 32] = init_word(a);
        return f;
    endfunction

    localparam logic [DEP*32-1:0] INIT_MAIN = build_init();

    function automatic logic [31:0] lane_mask(logic [3:0] we, int lane);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) m[b] = we[b / lane];
        return m;
    endfunction

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    // main configuration: A 8-bit old-data, B 16-bit new-data
    logic [3:0]  a_addr, b_addr;
    logic [3:0]  a_we;
    logic [1:0]  b_we;
    logic        a_re, b_re;
    logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;

    // alternate configuration: A whole word hold-mode, B 8-bit combinational
    logic [3:0]  x_a_addr, x_b_addr;
    logic [0:0]  x_a_we;
    logic [3:0]  x_b_we;
    logic        x_a_re, x_b_re;
    logic [31:0] x_a_wdata, x_b_wdata, x_a_rdata, x_b_rdata;

    mixed_grain_ram #(
        .WIDTH(32), .DEPTH(DEP), .GRAN_A(8), .GRAN_B(16),
        .MODE_A(RDW_OLD), .MODE_B(RDW_NEW), .ASYNC_A(1'b0), .ASYNC_B(1'b0),
        .INIT_FLAT(INIT_MAIN)
    ) u_mixed_grain_ram (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_we(a_we), .a_re(a_re), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_we(b_we), .b_re(b_re), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    mixed_grain_ram #(
        .WIDTH(32), .DEPTH(DEP), .GRAN_A(0), .GRAN_B(8),
        .MODE_A(RDW_HOLD), .MODE_B(RDW_OLD), .ASYNC_A(1'b0), .ASYNC_B(1'b1),
        .INIT_FLAT('0)
    ) u_alt (
        .clk(clk), .rst_n(rst_n),
        .a_addr(x_a_addr), .a_we(x_a_we), .a_re(x_a_re), .a_wdata(x_a_wdata), .a_rdata(x_a_rdata),
        .b_addr(x_b_addr), .b_we(x_b_we), .b_re(x_b_re), .b_wdata(x_b_wdata), .b_rdata(x_b_rdata)
    );

    int checks = 0;
    int errs   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] model [DEP];
    logic [31:0] last_a, last_b, ma, mb;
    logic [3:0]  aa, ba, awe;
    logic [1:0]  bwe;
    logic [31:0] awd, bwd;
    logic        are, bre;

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_addr = '0; b_addr = '0; a_we = '0; b_we = '0; a_re = 1'b1; b_re = 1'b1;
        a_wdata = '0; b_wdata = '0;
        x_a_addr = '0; x_b_addr = '0; x_a_we = '0; x_b_we = '0; x_a_re = 1'b1; x_b_re = 1'b0;
        x_a_wdata = '0; x_b_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R11", a_rdata, 32'h0);
        chk("R11", b_rdata, 32'h0);
        chk("R11", x_a_rdata, 32'h0);
        rst_n = 1'b1;

        // power-up contents through both ports
        for (int a = 0; a < DEP; a++) begin
            a_addr = 4'(a);
            b_addr = 4'(DEP - 1 - a);
            @(negedge clk);
            chk("R4", a_rdata, init_word(a));
            chk("R4", b_rdata, init_word(DEP - 1 - a));
        end
        for (int a = 0; a < DEP; a++) model[a] = init_word(a);
        last_a = init_word(DEP - 1);
        last_b = init_word(0);

        // random mixed traffic with frequent shared addresses
        for (int n = 0; n < 1500; n++) begin
            aa  = 4'($urandom_range(0, DEP - 1));
            ba  = ($urandom_range(0, 2) == 0) ? aa : 4'($urandom_range(0, DEP - 1));
            awe = 4'($urandom);
            bwe = 2'($urandom);
            awd = $urandom;
            bwd = $urandom;
            are = ($urandom_range(0, 3) != 0);
            bre = ($urandom_range(0, 3) != 0);
            a_addr = aa; b_addr = ba; a_we = awe; b_we = bwe;
            a_wdata = awd; b_wdata = bwd; a_re = are; b_re = bre;
            ma = lane_mask(awe, 8);
            mb = lane_mask({2'b00, bwe}, 16);
            if (are) last_a = model[aa];
            if (bre) last_b = (bwd & mb) | (model[ba] & ~mb);
            model[aa] = (model[aa] & ~ma) | (awd & ma);
            model[ba] = (model[ba] & ~mb) | (bwd & mb);
            @(negedge clk);
            chk(are ? "R7" : "R5", a_rdata, last_a);
            chk(bre ? "R8" : "R5", b_rdata, last_b);
        end
        a_we = '0; b_we = '0; a_re = 1'b1; b_re = 1'b0;

        // stored contents after traffic (lane enables and B priority, R3 and R10)
        for (int a = 0; a < DEP; a++) begin
            a_addr = 4'(a);
            @(negedge clk);
            chk("R3", a_rdata, model[a]);
        end

        // directed same-lane clash
        a_addr = 4'd5; b_addr = 4'd5; a_we = 4'hF; b_we = 2'b01;
        a_wdata = 32'h1111_1111; b_wdata = 32'h2222_2222; a_re = 1'b0;
        @(negedge clk);
        a_we = '0; b_we = '0; a_re = 1'b1;
        @(negedge clk);
        chk("R10", a_rdata, 32'h1111_2222);

        // cross-port slice ordering: B full word, A one byte, zero-enable A write
        b_addr = 4'd9; b_we = 2'b11; b_wdata = 32'h1122_3344;
        @(negedge clk);
        b_we = '0;
        a_addr = 4'd9; a_we = 4'b0100; a_wdata = 32'hAABB_CCDD; a_re = 1'b0;
        @(negedge clk);
        a_we = 4'b0000; a_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        b_re = 1'b1;
        @(negedge clk);
        chk("R2", b_rdata, 32'h11BB_3344);
        chk("R3", b_rdata[31:24], 8'h11);
        b_re = 1'b0;

        // alternate: whole-word enable, combinational read, hold mode
        x_a_addr = 4'd2; x_a_we = 1'b1; x_a_wdata = 32'hCAFE_F00D; x_a_re = 1'b0;
        x_b_addr = 4'd2;
        @(negedge clk);
        x_a_we = 1'b0;
        chk("R1", x_b_rdata, 32'hCAFE_F00D);
        x_b_we = 4'b0010; x_b_wdata = 32'h0000_5500;
        @(negedge clk);
        x_b_we = '0;
        chk("R6", x_b_rdata, 32'hCAFE_550D);
        x_b_addr = 4'd3;
        #1;
        chk("R6", x_b_rdata, 32'h0);
        x_b_addr = 4'd2;
        x_a_re = 1'b1;
        @(negedge clk);
        chk("R9", x_a_rdata, 32'hCAFE_550D);
        x_a_we = 1'b1; x_a_wdata = 32'h1234_5678;
        @(negedge clk);
        x_a_we = 1'b0;
        chk("R9", x_a_rdata, 32'hCAFE_550D);
        chk("R1", x_b_rdata, 32'h1234_5678);
        @(negedge clk);
        chk("R9", x_a_rdata, 32'h1234_5678);
        x_a_re = 1'b0;
        x_a_addr = 4'd0;
        @(negedge clk);
        chk("R5", x_a_rdata, 32'h1234_5678);

        // reset clears read registers but not contents
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", x_a_rdata, 32'h0);
        rst_n = 1'b1;
        x_a_addr = 4'd2; x_a_re = 1'b1;
        @(negedge clk);
        chk("R11", x_a_rdata, 32'h1234_5678);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule